// File: doc/BRIEF.md
# Vectored Two-Level Priority Interrupt Controller

This block gathers level-sensitive request flags from up to 64 peripheral sources and steers the CPU straight to the handler of the winning source, so no software has to poll the flags. Each source carries its own enable bit and a bit that places it in the high or the low class, and each class has its own global enable. Among the eligible requests in a class, the lowest source index wins. The block forms the address of the winner's handler-pointer slot from a relocatable table base.

The block raises a one-cycle entry pulse a fixed three clock edges after it captures a winner. With the pulse it presents the slot address, the source index and the class. A small two-deep record of active classes lets a high-class request interrupt a running low-class handler. No request interrupts a high-class handler, and a low-class request waits until no handler is active. A return strobe from the CPU removes the most recent class from the record. The block never clears the flags; software does that.

The entry pulse is a plain control output with no ready input, so there is no back-pressure. The CPU side must act on the cycle the pulse is high. The vector outputs keep their values until the next entry.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset, `enter` is 0, `act_lvl` is 2'b00, and `vec_idx`, `vec_hi` and `vec_addr` are 0.
- R2: A source whose `src_en` bit is 0 never causes an entry, whatever its flag.
- R3: With `glb_hi_en` at 0, no high-class request (`src_hi`=1) is taken. With `glb_lo_en` at 0, no low-class request (`src_hi`=0) is taken. The other class is unaffected.
- R4: Among eligible requests that the current state allows, high class wins. Within a class, the lowest source index wins.
- R5: A high-class request is taken while no handler or a low-class handler is active. It is not taken while a high-class handler is active.
- R6: A low-class request is taken only when `act_lvl` is 2'b00.
- R7: At entry, `vec_addr` = `tbl_base` + 2*`vec_idx`, modulo 2^AW. `vec_idx` is the winner's index and `vec_hi` is its class.
- R8: `enter` is high for exactly one cycle, in the cycle after the third clock edge that follows the capture edge. The capture edge is the first edge at which the request is eligible while no entry sequence is running.
- R9: `act_lvl` encodes the record as 00 (none), 01 (low), 10 (high), 11 (high over low). An entry pushes its class at the entry edge. `irq_ret` pops the newest class: 11→01, 10→00, 01→00.
- R10: Flags are never cleared by the block. A flag still high after its handler returns is taken again.
- R11: A captured winner is held through its entry sequence. Requests that change mid-sequence do not alter it. A high-class request that arrives during a low-class sequence is taken at the first arbitration after that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_flag | input | NSRC | Level request flag per source |
| src_en | input | NSRC | Per-source enable |
| src_hi | input | NSRC | Per-source class: 1 high, 0 low |
| glb_hi_en | input | 1 | Global enable of the high class |
| glb_lo_en | input | 1 | Global enable of the low class |
| tbl_base | input | AW | Handler-pointer table base address |
| irq_ret | input | 1 | Return-from-handler strobe |
| enter | output | 1 | One-cycle handler entry pulse |
| vec_idx | output | $clog2(NSRC) | Index of the entered source |
| vec_hi | output | 1 | Class of the entered source |
| vec_addr | output | AW | Address of the handler-pointer slot |
| act_lvl | output | 2 | Active-class record |

## Verification
The bench uses requests of both classes, with the high source at the larger index. A design that ranked by index alone would serve the low source first. A second high request made while a high handler runs shows whether the block lets a class interrupt itself. Low requests made while a low handler is active show whether it lets a low handler be interrupted. A winner is swapped mid-sequence to show whether the latched index drifts. A table base near the top of the address space makes a sum that fails to wrap or that scales the index wrongly show up as a bad address. Each entry is sampled at the exact cycle, so an extra or a missing pipeline register fails the latency check, and a flag held over a return catches a block that clears flags or loses the pending request.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  // active-class record encoding
  typedef enum logic [1:0] {
    LV_NONE  = 2'b00,
    LV_LO    = 2'b01,
    LV_HI    = 2'b10,
    LV_HI_LO = 2'b11
  } lvl_t;

  // edges from capture to the entry pulse
  localparam int ENTRY_LAT = 3;

  function automatic lvl_t lvl_pop(input lvl_t s);
    case (s)
      LV_HI_LO: return LV_LO;
      default:  return LV_NONE;
    endcase
  endfunction

  function automatic lvl_t lvl_push(input lvl_t s, input logic hi);
    if (hi) return (s == LV_LO) ? LV_HI_LO : LV_HI;
    return (s == LV_NONE) ? LV_LO : s;
  endfunction

endpackage

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);

  // fixed priority: the lowest set index wins
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/vpic_level_stack.sv
module vpic_level_stack
  import vpic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output lvl_t lvl
);

  lvl_t nxt;

  // a return and an entry on one edge: pop first, then push
  always_comb begin
    nxt = lvl;
    if (pop)  nxt = lvl_pop(nxt);
    if (push) nxt = lvl_push(nxt, push_hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl <= LV_NONE;
    else        lvl <= nxt;
  end

  // R9
  pop_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && lvl == LV_LO) |=> (lvl == LV_NONE));

  // R9
  pop_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && lvl == LV_HI_LO) |=> (lvl == LV_LO));

endmodule

// File: rtl/vpic_entry_seq.sv
module vpic_entry_seq
  import vpic_pkg::*;
#(
  parameter int IW = 6,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [IW-1:0] cap_idx,
  input  logic          cap_hi,
  input  logic [AW-1:0] tbl_base,
  output logic          busy,
  output logic          push,
  output logic          push_hi,
  output logic          enter,
  output logic [IW-1:0] vec_idx,
  output logic          vec_hi,
  output logic [AW-1:0] vec_addr
);

  localparam int CW = $clog2(ENTRY_LAT + 1);

  logic [CW-1:0] cnt;
  logic [IW-1:0] lat_idx;
  logic          lat_hi;

  assign push    = busy && (cnt == CW'(ENTRY_LAT));
  assign push_hi = lat_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      lat_idx  <= '0;
      lat_hi   <= 1'b0;
      enter    <= 1'b0;
      vec_idx  <= '0;
      vec_hi   <= 1'b0;
      vec_addr <= '0;
    end else begin
      enter <= 1'b0;
      if (!busy) begin
        if (cap) begin
          busy    <= 1'b1;
          cnt     <= CW'(1);
          lat_idx <= cap_idx;
          lat_hi  <= cap_hi;
        end
      end else if (push) begin
        busy     <= 1'b0;
        enter    <= 1'b1;
        vec_idx  <= lat_idx;
        vec_hi   <= lat_hi;
        vec_addr <= tbl_base + AW'({lat_idx, 1'b0});
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R8
  entry_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> $past(cap, ENTRY_LAT + 1));

  // R8
  enter_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> !enter);

endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = 16,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic            glb_hi_en,
  input  logic            glb_lo_en,
  input  logic [AW-1:0]   tbl_base,
  input  logic            irq_ret,
  output logic            enter,
  output logic [IW-1:0]   vec_idx,
  output logic            vec_hi,
  output logic [AW-1:0]   vec_addr,
  output logic [1:0]      act_lvl
);

  logic [NSRC-1:0] hi_req, lo_req;
  logic            hi_valid, lo_valid;
  logic [IW-1:0]   hi_idx, lo_idx;
  logic            take_hi, take_lo, cap, busy, push, push_hi;
  lvl_t            lvl;

  assign hi_req = irq_flag & src_en &  src_hi & {NSRC{glb_hi_en}};
  assign lo_req = irq_flag & src_en & ~src_hi & {NSRC{glb_lo_en}};

  vpic_arbiter #(.N(NSRC), .IW(IW)) u_arb_hi (
    .req(hi_req), .valid(hi_valid), .idx(hi_idx));
  vpic_arbiter #(.N(NSRC), .IW(IW)) u_arb_lo (
    .req(lo_req), .valid(lo_valid), .idx(lo_idx));

  // high class may interrupt low only; low class only from idle
  assign take_hi = hi_valid && !lvl[1];
  assign take_lo = lo_valid && (lvl == LV_NONE);
  assign cap     = !busy && (take_hi || take_lo);

  vpic_entry_seq #(.IW(IW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cap(cap),
    .cap_idx(take_hi ? hi_idx : lo_idx), .cap_hi(take_hi),
    .tbl_base(tbl_base), .busy(busy), .push(push), .push_hi(push_hi),
    .enter(enter), .vec_idx(vec_idx), .vec_hi(vec_hi), .vec_addr(vec_addr));

  vpic_level_stack u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_hi(push_hi),
    .pop(irq_ret), .lvl(lvl));

  assign act_lvl = lvl;

  // R4
  arb_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_valid |-> (hi_req[hi_idx] &&
      ((hi_req & ((NSRC'(1) << hi_idx) - NSRC'(1))) == '0)));

  // R6
  lo_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !vec_hi) |-> ($past(act_lvl) == 2'b00));

  // R5
  hi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && vec_hi) |-> act_lvl[1]);

endmodule

// File: tb/vpic_ctrl_bench.sv
module vpic_ctrl_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_flag = '0, src_en = '0, src_hi = '0;
  logic        glb_hi_en = 1'b0, glb_lo_en = 1'b0, irq_ret = 1'b0;
  logic [15:0] tbl_base = '0;
  logic        enter, vec_hi;
  logic [5:0]  vec_idx;
  logic [15:0] vec_addr;
  logic [1:0]  act_lvl;

  int checks = 0, errors = 0;

  always #(CLK_P / 2) clk = ~clk;

  vpic_ctrl u_vpic_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .src_en(src_en),
    .src_hi(src_hi), .glb_hi_en(glb_hi_en), .glb_lo_en(glb_lo_en),
    .tbl_base(tbl_base), .irq_ret(irq_ret), .enter(enter),
    .vec_idx(vec_idx), .vec_hi(vec_hi), .vec_addr(vec_addr),
    .act_lvl(act_lvl));

  typedef struct packed {
    logic [63:0] flg, en, hi;
    logic        ghi, glo;
    logic [15:0] base;
    logic        take;
    logic [5:0]  idx;
    logic        vhi;
    logic [15:0] addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R7: single low source, base offset
    '{64'h20, 64'h20, 64'h0, 1'b1, 1'b1, 16'h1000, 1'b1, 6'd5, 1'b0, 16'h100A},
    // R4: index 0 before index 25
    '{64'h0200_0001, 64'h0200_0001, 64'h0, 1'b1, 1'b1, 16'h2000, 1'b1, 6'd0, 1'b0, 16'h2000},
    // R5: high 40 beats low 3
    '{64'h0000_0100_0000_0008, 64'h0000_0100_0000_0008, 64'h0000_0100_0000_0000,
      1'b1, 1'b1, 16'h0100, 1'b1, 6'd40, 1'b1, 16'h0150},
    // R2: flag of a disabled source
    '{64'h80, 64'h0, 64'h0, 1'b1, 1'b1, 16'h3000, 1'b0, 6'd0, 1'b0, 16'h0},
    // R3: high class globally off
    '{64'h1000, 64'h1000, 64'h1000, 1'b0, 1'b1, 16'h0, 1'b0, 6'd0, 1'b0, 16'h0},
    // R3: high off, low class still served
    '{64'h4000_1000, 64'h4000_1000, 64'h1000, 1'b0, 1'b1, 16'h0400, 1'b1, 6'd30, 1'b0, 16'h043C},
    // R3: low class globally off
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b0, 16'h0,
      1'b0, 6'd0, 1'b0, 16'h0},
    // R7: wrap of the address sum
    '{64'hC000_0000_0000_0000, 64'hC000_0000_0000_0000, 64'hC000_0000_0000_0000,
      1'b1, 1'b1, 16'hFFF0, 1'b1, 6'd62, 1'b1, 16'h006C},
    // R7: top index
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b1, 16'h0000,
      1'b1, 6'd63, 1'b0, 16'h007E},
    // R2: lower disabled flag skipped
    '{64'hF0, 64'hE0, 64'h0, 1'b1, 1'b1, 16'h0010, 1'b1, 6'd5, 1'b0, 16'h001A}
  };

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  // capture on the first edge after the call; enter seen after the fourth
  task automatic expect_entry(input logic [5:0] idx, input logic hi,
                              input logic [15:0] addr, input string tag);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk({tag, " early enter"}, 64'(enter), 64'd0);
    end
    @(negedge clk);
    chk({tag, " enter"}, 64'(enter), 64'd1);
    chk({tag, " idx"}, 64'(vec_idx), 64'(idx));
    chk({tag, " class"}, 64'(vec_hi), 64'(hi));
    chk({tag, " addr"}, 64'(vec_addr), 64'(addr));
  endtask

  task automatic expect_quiet(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk({tag, " no entry"}, 64'(enter), 64'd0);
    end
  endtask

  task automatic do_ret();
    irq_ret = 1'b1;
    @(negedge clk);
    irq_ret = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_P * 20000);
    $display("FAIL watchdog: run hung, got timeout expected finish");
    errors++;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 enter", 64'(enter), 64'd0);
    chk("R1 act_lvl", 64'(act_lvl), 64'd0);
    chk("R1 vec_idx", 64'(vec_idx), 64'd0);
    chk("R1 vec_hi", 64'(vec_hi), 64'd0);
    chk("R1 vec_addr", 64'(vec_addr), 64'd0);

    for (int v = 0; v < NV; v++) begin
      irq_flag = VECS[v].flg; src_en = VECS[v].en; src_hi = VECS[v].hi;
      glb_hi_en = VECS[v].ghi; glb_lo_en = VECS[v].glo; tbl_base = VECS[v].base;
      if (VECS[v].take) begin
        expect_entry(VECS[v].idx, VECS[v].vhi, VECS[v].addr, $sformatf("vec%0d R4/R7", v));
        chk($sformatf("vec%0d R9 act", v), 64'(act_lvl), VECS[v].vhi ? 64'd2 : 64'd1);
        @(negedge clk);
        chk($sformatf("vec%0d R8 pulse", v), 64'(enter), 64'd0);
        irq_flag = '0;
        do_ret();
        chk($sformatf("vec%0d R9 pop", v), 64'(act_lvl), 64'd0);
      end else begin
        expect_quiet(6, $sformatf("vec%0d R2/R3", v));
        chk($sformatf("vec%0d R2/R3 act", v), 64'(act_lvl), 64'd0);
        irq_flag = '0;
        @(negedge clk);
      end
    end

    // R5 R6 R9: nesting
    glb_hi_en = 1'b1; glb_lo_en = 1'b1; tbl_base = 16'h0800;
    src_en = '1; src_hi = (64'd1 << 20) | (64'd1 << 1);
    irq_flag = 64'd1 << 10;
    expect_entry(6'd10, 1'b0, 16'h0814, "R6 low from idle");
    irq_flag = irq_flag | (64'd1 << 2);
    expect_quiet(6, "R6 low under low");
    irq_flag = irq_flag | (64'd1 << 20);
    expect_entry(6'd20, 1'b1, 16'h0828, "R5 high preempts low");
    chk("R9 high over low", 64'(act_lvl), 64'd3);
    irq_flag = irq_flag | (64'd1 << 1);
    expect_quiet(6, "R5 high under high");
    irq_flag = irq_flag & ~((64'd1 << 1) | (64'd1 << 20));
    do_ret();
    chk("R9 pop to low", 64'(act_lvl), 64'd1);
    expect_quiet(4, "R6 low still blocked");
    irq_flag = irq_flag & ~(64'd1 << 10);
    do_ret();
    chk("R9 pop to none", 64'(act_lvl), 64'd0);
    expect_entry(6'd2, 1'b0, 16'h0804, "R6 waiting low taken");
    irq_flag = '0;
    do_ret();

    // R10: flag held over return is served again
    irq_flag = 64'd1 << 33;
    expect_entry(6'd33, 1'b0, 16'h0842, "R10 first");
    do_ret();
    expect_entry(6'd33, 1'b0, 16'h0842, "R10 again");
    irq_flag = '0;
    do_ret();
    chk("R10 idle", 64'(act_lvl), 64'd0);

    // R11: latched winner, then mid-sequence high taken next
    src_hi = 64'd1 << 50;
    irq_flag = 64'd1 << 8;
    @(negedge clk);
    chk("R11 early enter", 64'(enter), 64'd0);
    irq_flag = irq_flag | (64'd1 << 4) | (64'd1 << 50);
    @(negedge clk);
    chk("R11 early enter", 64'(enter), 64'd0);
    @(negedge clk);
    chk("R11 early enter", 64'(enter), 64'd0);
    @(negedge clk);
    chk("R11 enter", 64'(enter), 64'd1);
    chk("R11 latched idx", 64'(vec_idx), 64'd8);
    chk("R11 latched class", 64'(vec_hi), 64'd0);
    expect_entry(6'd50, 1'b1, 16'h0864, "R11 high after low");
    chk("R11 act", 64'(act_lvl), 64'd3);
    irq_flag = '0;
    do_ret();
    do_ret();
    chk("R9 back to none", 64'(act_lvl), 64'd0);

    summary();
    $finish;
  end

endmodule